// File: doc/BRIEF.md
# Pulse-and-Verify OTP Byte Programming Sequencer

This block burns an image into a one-time-programmable array one byte at a time. After a start request it raises the programming voltage and walks the address range from a first address to a last address, both inclusive. For each address it fetches the intended byte from a data source and drives it onto a shared bidirectional data bus. It then applies one program strobe of fixed width and reads the byte back. If the read-back differs, it strobes the same byte again. An address that still fails after ten attempts ends the run with a failure.

When every address has verified, the sequencer removes the programming voltage and runs a second full pass. This pass reads every byte at the normal supply and compares it with the source. A single mismatch in this pass fails the device. Pulse width, setup time, hold time and read access time are given in physical units and turned into clock counts from a clock-frequency parameter. The block reports its result on done, pass and fail, and these flags hold until the next start.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset the sequencer is idle: program strobe high (inactive), output enable high (inactive), memory-space select low, programming voltage off, done, pass and fail low, and the data bus released (high impedance).
- R2: A start request in idle clears done, pass and fail, latches the address range, and raises the programming voltage and the memory-space select. The voltage stays high for at least SETUP_CYC cycles before the first program strobe falls.
- R3: Control encoding: a program cycle has strobe 0, output enable 1, memory-space 1 and voltage on. A read cycle has strobe 1, output enable 0 and memory-space 1. The strobe and the output enable are never low together.
- R4: Every program strobe stays low for exactly PULSE_CYC = ceil(PULSE_US*CLK_KHZ/1000) cycles.
- R5: Data and address are driven at least SETUP_CYC = ceil(SETUP_NS*CLK_KHZ/1e6) cycles before the strobe falls. They stay unchanged while it is low and remain driven at least HOLD_CYC cycles after it rises. The bus is released whenever output enable is low.
- R6: Every strobe is followed by a verify read of the same address with the programming voltage still on. A byte that already holds its value still receives one strobe.
- R7: A failed verify gives another strobe at the same address. After MAX_TRY (10) failed verifies at one address the run stops with done=1, fail=1 and pass=0. No further strobes follow, and later addresses are left untouched.
- R8: A passing verify moves to the next address and clears the attempt count, so every address has its own budget of MAX_TRY strobes. An address that needs exactly MAX_TRY strobes still passes.
- R9: After the last address verifies, the voltage drops. Every byte from first to last is then read in ascending order with output enable low and voltage off, and compared with the source. The first mismatch ends the run with fail=1; if there is none the run ends with pass=1.
- R10: A start request, and any change of the address inputs, while a run is active has no effect on that run.
- R11: done, pass and fail keep their values after a run until the next start request; exactly one of pass and fail is high whenever done is high.
- R12: Addresses are strobed in ascending order from first to last inclusive, and no address outside that range is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| first_addr_i | input | AW | First address of the image |
| last_addr_i | input | AW | Last address of the image (inclusive) |
| src_addr_o | output | AW | Address presented to the data source |
| src_data_i | input | DW | Intended byte for src_addr_o, valid in the same cycle |
| mem_addr_o | output | AW | Array address |
| mem_data_io | inout | DW | Bidirectional array data bus |
| mem_pgm_n_o | output | 1 | Program strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_space_o | output | 1 | Memory-space select, high for program memory |
| vpp_en_o | output | 1 | Programming-voltage enable |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with every byte correct |
| fail_o | output | 1 | Run finished with a failure |

## Verification
The bench models an array that only sets bits, and only on the strobe at which an address has received its required count. It steers that count to the edge values: exactly ten strobes, which must pass, and eleven, which must stop the run after ten. An off-by-one retry counter would flip one of these two outcomes. Other cases are a byte that already matches but must still be strobed once, and a preloaded bit that can never be cleared. A cell that reads correctly only under programming voltage exposes a design that skips the final low-voltage compare. A start and a change of address inputs in the middle of a run show up as extra or misplaced strobes in a design that does not ignore them. Strobe width, setup lead and data hold are measured at the pins on every strobe.

// File: rtl/otp_burn_pkg.sv
// Shared types and helpers for the OTP byte programming sequencer.
// Assumes timing parameters are small enough that their products fit 32 bits.
package otp_burn_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VPP_UP,
        S_LOAD,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_VERIFY,
        S_VPP_DN,
        S_CLOAD,
        S_CREAD
    } burn_state_e;

    typedef enum logic [2:0] {
        T_KEEP,
        T_INIT,
        T_NEXT,
        T_BUMP,
        T_REWIND
    } track_op_e;

    // Integer ceiling division.
    function automatic int unsigned cyc_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Clamp a cycle count to at least one cycle.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/otp_burn_timer.sv
// Down-counting interval timer for the sequencer's timed phases.
// A load of value V makes expired_o high after V further cycles, so a state
// that loads CYC-1 on entry and leaves on expiry lasts exactly CYC cycles.
module otp_burn_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    // Load a new interval or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/otp_burn_track.sv
// Address walker and attempt counter for the sequencer.
// Latches the address range on INIT; NEXT advances and clears the attempt
// count, BUMP counts one failed verify, REWIND returns to the first address.
// Assumes first <= last; the walk never passes the latched last address.
module otp_burn_track
    import otp_burn_pkg::*;
#(
    parameter int unsigned AW      = 15,
    parameter int unsigned MAX_TRY = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  track_op_e     op_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    output logic [AW-1:0] addr_o,
    output logic          at_last_o,
    output logic          out_of_tries_o
);

    localparam int unsigned RW = $clog2(MAX_TRY + 1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] first_q;
    logic [AW-1:0] last_q;
    logic [RW-1:0] tries_q;

    // Latch the range and walk the address as the controller directs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
        end else begin
            unique case (op_i)
                T_INIT: begin
                    addr_q  <= first_i;
                    first_q <= first_i;
                    last_q  <= last_i;
                end
                T_NEXT:   addr_q <= addr_q + 1'b1;
                T_REWIND: addr_q <= first_q;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    // Count failed verifies at the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else begin
            unique case (op_i)
                T_INIT, T_NEXT, T_REWIND: tries_q <= '0;
                T_BUMP:                   tries_q <= tries_q + 1'b1;
                default:                  tries_q <= tries_q;
            endcase
        end
    end

    assign addr_o         = addr_q;
    assign at_last_o      = (addr_q == last_q);
    assign out_of_tries_o = (tries_q == RW'(MAX_TRY - 1));

endmodule

// File: rtl/otp_burn_seq.sv
// Pulse-and-verify OTP programming sequencer (top).
// Strobes each byte up to MAX_TRY times with a verify read after each strobe,
// then compares the whole range at normal supply. Timing parameters are in
// physical units and converted to cycles from CLK_KHZ. Assumes the data
// source answers combinationally and the array drives the bus only while
// output enable is low.
module otp_burn_seq
    import otp_burn_pkg::*;
#(
    parameter int unsigned AW        = 15,
    parameter int unsigned DW        = 8,
    parameter int unsigned CLK_KHZ   = 200000,
    parameter int unsigned PULSE_US  = 1000,
    parameter int unsigned SETUP_NS  = 2000,
    parameter int unsigned HOLD_NS   = 2000,
    parameter int unsigned ACCESS_NS = 75,
    parameter int unsigned MAX_TRY   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] first_addr_i,
    input  logic [AW-1:0] last_addr_i,
    output logic [AW-1:0] src_addr_o,
    input  logic [DW-1:0] src_data_i,
    output logic [AW-1:0] mem_addr_o,
    inout  wire  [DW-1:0] mem_data_io,
    output logic          mem_pgm_n_o,
    output logic          mem_oe_n_o,
    output logic          mem_space_o,
    output logic          vpp_en_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o
);

    localparam int unsigned PULSE_CYC = at_least_one(cyc_ceil(PULSE_US * CLK_KHZ, 1000));
    localparam int unsigned SETUP_CYC = at_least_one(cyc_ceil(SETUP_NS * CLK_KHZ, 1000000));
    localparam int unsigned HOLD_CYC  = at_least_one(cyc_ceil(HOLD_NS * CLK_KHZ, 1000000));
    localparam int unsigned ACC_CYC   = at_least_one(cyc_ceil(ACCESS_NS * CLK_KHZ, 1000000));
    localparam int unsigned MAX_CYC   = max2(max2(PULSE_CYC, SETUP_CYC), max2(HOLD_CYC, ACC_CYC));
    localparam int unsigned TW        = $clog2(MAX_CYC + 1);

    burn_state_e   st_q, st_d;
    track_op_e     trk_op;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic [AW-1:0] cur_addr;
    logic          at_last;
    logic          out_of_tries;
    logic [DW-1:0] wbyte_q;
    logic          wb_load;
    logic          rd_match;
    logic          bus_drive;
    logic          res_clr;
    logic          res_set;
    logic          res_pass;
    logic          done_q, pass_q, fail_q;

    otp_burn_timer #(
        .TW(TW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_exp)
    );

    otp_burn_track #(
        .AW     (AW),
        .MAX_TRY(MAX_TRY)
    ) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_i          (trk_op),
        .first_i       (first_addr_i),
        .last_i        (last_addr_i),
        .addr_o        (cur_addr),
        .at_last_o     (at_last),
        .out_of_tries_o(out_of_tries)
    );

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Capture the intended byte from the source for the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte_q <= '0;
        end else if (wb_load) begin
            wbyte_q <= src_data_i;
        end
    end

    // Hold the run result until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || res_clr) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (res_set) begin
            done_q <= 1'b1;
            pass_q <= res_pass;
            fail_q <= !res_pass;
        end
    end

    assign rd_match = (mem_data_io == wbyte_q);

    // Choose the next state, timer reload, tracker operation and result.
    always_comb begin
        st_d     = st_q;
        trk_op   = T_KEEP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        wb_load  = 1'b0;
        res_clr  = 1'b0;
        res_set  = 1'b0;
        res_pass = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    st_d     = S_VPP_UP;
                    trk_op   = T_INIT;
                    res_clr  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            S_VPP_UP: begin
                if (tmr_exp) begin
                    st_d = S_LOAD;
                end
            end
            S_LOAD: begin
                wb_load  = 1'b1;
                st_d     = S_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETUP_CYC - 1);
            end
            S_SETUP: begin
                if (tmr_exp) begin
                    st_d     = S_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                end
            end
            S_PULSE: begin
                if (tmr_exp) begin
                    st_d     = S_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                end
            end
            S_HOLD: begin
                if (tmr_exp) begin
                    st_d     = S_VERIFY;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ACC_CYC - 1);
                end
            end
            S_VERIFY: begin
                if (tmr_exp) begin
                    if (rd_match) begin
                        if (at_last) begin
                            st_d     = S_VPP_DN;
                            trk_op   = T_REWIND;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(SETUP_CYC - 1);
                        end else begin
                            st_d   = S_LOAD;
                            trk_op = T_NEXT;
                        end
                    end else if (out_of_tries) begin
                        st_d     = S_IDLE;
                        res_set  = 1'b1;
                        res_pass = 1'b0;
                    end else begin
                        st_d     = S_SETUP;
                        trk_op   = T_BUMP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SETUP_CYC - 1);
                    end
                end
            end
            S_VPP_DN: begin
                if (tmr_exp) begin
                    st_d = S_CLOAD;
                end
            end
            S_CLOAD: begin
                wb_load  = 1'b1;
                st_d     = S_CREAD;
                tmr_load = 1'b1;
                tmr_val  = TW'(ACC_CYC - 1);
            end
            S_CREAD: begin
                if (tmr_exp) begin
                    if (!rd_match) begin
                        st_d     = S_IDLE;
                        res_set  = 1'b1;
                        res_pass = 1'b0;
                    end else if (at_last) begin
                        st_d     = S_IDLE;
                        res_set  = 1'b1;
                        res_pass = 1'b1;
                    end else begin
                        st_d   = S_CLOAD;
                        trk_op = T_NEXT;
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Decode the array control pins from the state.
    always_comb begin
        mem_pgm_n_o = 1'b1;
        mem_oe_n_o  = 1'b1;
        vpp_en_o    = 1'b0;
        bus_drive   = 1'b0;
        unique case (st_q)
            S_VPP_UP, S_LOAD: vpp_en_o = 1'b1;
            S_SETUP, S_HOLD: begin
                vpp_en_o  = 1'b1;
                bus_drive = 1'b1;
            end
            S_PULSE: begin
                vpp_en_o    = 1'b1;
                bus_drive   = 1'b1;
                mem_pgm_n_o = 1'b0;
            end
            S_VERIFY: begin
                vpp_en_o   = 1'b1;
                mem_oe_n_o = 1'b0;
            end
            S_CREAD: mem_oe_n_o = 1'b0;
            default: ;
        endcase
    end

    assign mem_space_o = (st_q != S_IDLE);
    assign mem_addr_o  = cur_addr;
    assign src_addr_o  = cur_addr;
    assign mem_data_io = bus_drive ? wbyte_q : {DW{1'bz}};
    assign done_o      = done_q;
    assign pass_o      = pass_q;
    assign fail_o      = fail_q;

endmodule

// File: rtl/otp_burn_chk.sv
// Protocol checker for the OTP programming sequencer, bound to its top.
// Measures strobe width, voltage lead, data lead and hold, and strobes per
// address with small counters; assumes the timing parameters of the top.
module otp_burn_chk #(
    parameter int unsigned AW        = 15,
    parameter int unsigned PULSE_CYC = 4,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned MAX_TRY   = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pgm_n,
    input logic          oe_n,
    input logic          space,
    input logic          vpp,
    input logic          drive,
    input logic [AW-1:0] addr,
    input logic          done,
    input logic          pass,
    input logic          fail
);

    localparam int unsigned LW = $clog2(PULSE_CYC + 2);
    localparam int unsigned SW = $clog2(SETUP_CYC + HOLD_CYC + 2);
    localparam int unsigned PW = $clog2(MAX_TRY + 2);

    logic [LW-1:0] low_cnt;
    logic [SW-1:0] vpp_cnt;
    logic [SW-1:0] drv_cnt;
    logic [PW-1:0] pc_q;
    logic [AW-1:0] pa_q;
    logic          pgm_n_q;

    // Count consecutive low strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || pgm_n) low_cnt <= '0;
        else if (low_cnt != LW'(PULSE_CYC + 1)) low_cnt <= low_cnt + 1'b1;
    end

    // Count cycles the programming voltage has been on.
    always_ff @(posedge clk) begin
        if (!rst_n || !vpp) vpp_cnt <= '0;
        else if (vpp_cnt != SW'(SETUP_CYC + HOLD_CYC + 1)) vpp_cnt <= vpp_cnt + 1'b1;
    end

    // Count driven cycles around a strobe, restarting at each edge of it.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive || !pgm_n) drv_cnt <= '0;
        else if (drv_cnt != SW'(SETUP_CYC + HOLD_CYC + 1)) drv_cnt <= drv_cnt + 1'b1;
    end

    // Count strobes delivered to the same address within one run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_n_q <= 1'b1;
            pc_q    <= '0;
            pa_q    <= '0;
        end else begin
            pgm_n_q <= pgm_n;
            if (!space) begin
                pc_q <= '0;
            end else if (pgm_n_q && !pgm_n) begin
                pa_q <= addr;
                if (pc_q != '0 && pa_q == addr) begin
                    if (pc_q != PW'(MAX_TRY + 1)) pc_q <= pc_q + 1'b1;
                end else begin
                    pc_q <= 1;
                end
            end
        end
    end

    AST_NO_DOUBLE_LOW:   assert property (@(posedge clk) disable iff (!rst_n) !(!pgm_n && !oe_n));                          // R3
    AST_STROBE_CONTEXT:  assert property (@(posedge clk) disable iff (!rst_n) !pgm_n |-> vpp && space && drive);          // R3
    AST_READ_CONTEXT:    assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> space);                           // R3
    AST_BUS_RELEASED:    assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !drive);                          // R5
    AST_PULSE_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n) $rose(pgm_n) |-> low_cnt == LW'(PULSE_CYC)); // R4
    AST_VPP_LEAD:        assert property (@(posedge clk) disable iff (!rst_n) $fell(pgm_n) |-> vpp_cnt >= SW'(SETUP_CYC)); // R2
    AST_DATA_LEAD:       assert property (@(posedge clk) disable iff (!rst_n) $fell(pgm_n) |-> drv_cnt >= SW'(SETUP_CYC)); // R5
    AST_DATA_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) $fell(drive) |-> drv_cnt >= SW'(HOLD_CYC));  // R5
    AST_ADDR_STEADY:     assert property (@(posedge clk) disable iff (!rst_n) !pgm_n && $past(!pgm_n) |-> $stable(addr)); // R5
    AST_TRY_LIMIT:       assert property (@(posedge clk) disable iff (!rst_n) pc_q <= PW'(MAX_TRY));                      // R7
    AST_RESULT_ONE:      assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass ^ fail));                    // R11
    AST_RESULT_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !done |-> !pass && !fail);                  // R11
    AST_DONE_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) done |-> pgm_n && oe_n && !vpp);            // R7

endmodule

bind otp_burn_seq otp_burn_chk #(
    .AW       (AW),
    .PULSE_CYC(PULSE_CYC),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .MAX_TRY  (MAX_TRY)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .pgm_n(mem_pgm_n_o),
    .oe_n (mem_oe_n_o),
    .space(mem_space_o),
    .vpp  (vpp_en_o),
    .drive(bus_drive),
    .addr (mem_addr_o),
    .done (done_o),
    .pass (pass_o),
    .fail (fail_o)
);

// File: tb/otp_burn_seq_bench.sv
// Bench for the OTP programming sequencer: a behavioural array that sets bits
// only on the strobe at which an address reaches its required strobe count,
// plus a read disturbance visible only with the programming voltage off.
`timescale 1ns/1ps
module otp_burn_seq_bench;

    localparam int AW        = 4;
    localparam int DW        = 8;
    localparam int N         = 1 << AW;
    localparam int CLK_KHZ   = 2000;
    localparam int PULSE_US  = 10;
    localparam int SETUP_NS  = 2000;
    localparam int HOLD_NS   = 2000;
    localparam int ACCESS_NS = 75;
    localparam int MAXT      = 10;
    localparam int PULSE_EXP = (PULSE_US * CLK_KHZ + 999) / 1000;
    localparam int SETUP_EXP = (SETUP_NS * CLK_KHZ + 999999) / 1000000;
    localparam int HOLD_EXP  = (HOLD_NS * CLK_KHZ + 999999) / 1000000;
    localparam int ACC_EXP   = (ACCESS_NS * CLK_KHZ + 999999) / 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] maddr;
    tri   [DW-1:0] mem_bus;
    logic          pgm_n, oe_n, space, vpp, done, pass, fail;

    logic [DW-1:0] arr [N];
    logic [DW-1:0] srcmem [N];
    logic [DW-1:0] leak [N];
    int            need [N];
    int            pcount [N];
    logic [DW-1:0] exp_arr [N];
    int            exp_pc [N];
    bit            exp_pass;
    int            exp_hi, exp_lo;
    int            hi_reads, lo_reads;
    int            vpp_run, drv_run, low_run, prev_pa, rfirst, rlast;
    logic          pgm_q = 1'b1;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;
    int            vectors = 0;
    int            fails = 0;
    bit            finished = 0;

    always #2.5 clk = ~clk;

    assign mem_bus = (!oe_n && pgm_n) ? (arr[maddr] ^ (vpp ? 8'h00 : leak[maddr])) : {DW{1'bz}};

    otp_burn_seq #(
        .AW(AW), .DW(DW), .CLK_KHZ(CLK_KHZ), .PULSE_US(PULSE_US),
        .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS), .ACCESS_NS(ACCESS_NS), .MAX_TRY(MAXT)
    ) u_otp_burn_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .first_addr_i(first_addr), .last_addr_i(last_addr),
        .src_addr_o(src_addr), .src_data_i(srcmem[src_addr]),
        .mem_addr_o(maddr), .mem_data_io(mem_bus),
        .mem_pgm_n_o(pgm_n), .mem_oe_n_o(oe_n), .mem_space_o(space),
        .vpp_en_o(vpp), .done_o(done), .pass_o(pass), .fail_o(fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Array model and pin-level timing measurement, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!oe_n && vpp) hi_reads++;
            if (!oe_n && !vpp) lo_reads++;
            if (!pgm_n && pgm_q) begin
                chk(vpp_run >= SETUP_EXP, "R2 voltage lead", vpp_run, SETUP_EXP);
                chk(drv_run >= SETUP_EXP, "R5 data lead", drv_run, SETUP_EXP);
                chk(oe_n && space && vpp, "R3 program encoding", {oe_n, space, vpp}, 7);
                chk(int'(maddr) >= rfirst && int'(maddr) <= rlast && int'(maddr) >= prev_pa,
                    "R12 strobe order", maddr, prev_pa);
                prev_pa = maddr;
                pcount[maddr]++;
                if (pcount[maddr] >= need[maddr]) arr[maddr] = arr[maddr] | mem_bus;
                p_addr  = maddr;
                p_data  = mem_bus;
                low_run = 1;
                drv_run = 0;
            end else if (!pgm_n) begin
                low_run++;
            end else if (!pgm_q) begin
                chk(low_run == PULSE_EXP, "R4 strobe width", low_run, PULSE_EXP);
                chk(maddr == p_addr && mem_bus === p_data, "R5 data hold", mem_bus, p_data);
            end
            if (!oe_n) chk(pgm_n, "R3 read encoding", pgm_n, 1);
            vpp_run = vpp ? vpp_run + 1 : 0;
            if (pgm_n && oe_n && mem_bus !== {DW{1'bz}}) drv_run++;
            else if (pgm_n) drv_run = 0;
        end
        pgm_q = pgm_n;
    end

    // Expected strobe counts, final contents, verdict and read counts.
    task automatic predict(input int first, input int last);
        bit stop = 0;
        int tot = 0;
        exp_pass = 1;
        exp_lo = 0;
        for (int a = 0; a < N; a++) begin
            exp_pc[a]  = 0;
            exp_arr[a] = arr[a];
        end
        for (int a = first; a <= last && !stop; a++) begin
            logic [DW-1:0] d = srcmem[a];
            logic [DW-1:0] pre = arr[a];
            if (pre == d) begin
                exp_pc[a] = 1;
            end else if ((pre & ~d) == 0 && need[a] <= MAXT) begin
                exp_pc[a]  = need[a];
                exp_arr[a] = d;
            end else begin
                exp_pc[a]  = MAXT;
                exp_arr[a] = pre | ((need[a] <= MAXT) ? d : 8'h00);
                exp_pass   = 0;
                stop       = 1;
            end
            tot += exp_pc[a];
        end
        exp_hi = tot * ACC_EXP;
        if (!stop) begin
            for (int a = first; a <= last && !stop; a++) begin
                exp_lo += ACC_EXP;
                if (leak[a] != 0) begin
                    exp_pass = 0;
                    stop     = 1;
                end
            end
        end
    endtask

    task automatic prep(input int maxneed);
        for (int a = 0; a < N; a++) begin
            arr[a]    = 8'h00;
            leak[a]   = 8'h00;
            srcmem[a] = 8'($urandom);
            need[a]   = 1 + int'($urandom % maxneed);
            pcount[a] = 0;
        end
    endtask

    task automatic run_case(input int first, input int last, input bit poke, input string tag);
        int cyc = 0;
        predict(first, last);
        hi_reads = 0;
        lo_reads = 0;
        prev_pa  = -1;
        rfirst   = first;
        rlast    = last;
        first_addr = AW'(first);
        last_addr  = AW'(last);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !pass && !fail, "R11 flags cleared by start", done, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            first_addr = '0;
            last_addr  = AW'(N - 1);
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, {tag, " R7 run completes"}, done, 1);
        chk(pass == exp_pass && fail == !exp_pass, {tag, " R9 verdict"}, pass, exp_pass);
        for (int a = 0; a < N; a++) begin
            chk(pcount[a] == exp_pc[a], {tag, " R8 strobes per address"}, pcount[a], exp_pc[a]);
            chk(arr[a] == exp_arr[a], {tag, " R12 array contents"}, arr[a], exp_arr[a]);
        end
        chk(hi_reads == exp_hi, {tag, " R6 verify reads"}, hi_reads, exp_hi);
        chk(lo_reads == exp_lo, {tag, " R9 final compare reads"}, lo_reads, exp_lo);
        repeat (30) @(negedge clk);
        chk(done && pass == exp_pass, {tag, " R11 result held"}, pass, exp_pass);
        if (poke) chk(pcount[0] == exp_pc[0], "R10 start while busy ignored", pcount[0], exp_pc[0]);
    endtask

    initial begin
        void'($urandom(32'd1957));
        for (int a = 0; a < N; a++) begin
            arr[a] = 8'h00; leak[a] = 8'h00; srcmem[a] = 8'h00; need[a] = 1; pcount[a] = 0;
        end
        vpp_run = 0; drv_run = 0; low_run = 0; prev_pa = -1; rfirst = 0; rlast = 0;
        hi_reads = 0; lo_reads = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pgm_n && oe_n && !space && !vpp, "R1 idle controls", {pgm_n, oe_n, space, vpp}, 12);
        chk(!done && !pass && !fail, "R1 idle flags", {done, pass, fail}, 0);
        chk(mem_bus === {DW{1'bz}}, "R1 bus released", mem_bus, 0);

        prep(4);                          run_case(0, N - 1, 0, "full");
        prep(3); need[5] = MAXT;          run_case(2, 9, 0, "ten strobes R8");
        prep(3); need[6] = MAXT + 1;      run_case(2, 12, 0, "eleven strobes R7");
        prep(3); leak[9] = 8'h10;         run_case(1, 14, 0, "weak cell R9");
        prep(4);                          run_case(7, 7, 0, "single byte");
        prep(2); srcmem[3] = 8'h0F; arr[3] = 8'h30; run_case(0, 6, 0, "stuck bit R7");
        prep(5); arr[4] = srcmem[4];      run_case(4, 8, 0, "preset byte R6");
        prep(3);                          run_case(3, 10, 1, "busy start R10");
        prep(3);                          run_case(11, N - 1, 0, "top range");
        for (int k = 0; k < 4; k++) begin
            int f = int'($urandom % N);
            int l = f + int'($urandom % (N - f));
            prep(12);
            if (k == 1) leak[l] = 8'h01;
            run_case(f, l, 0, "random");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule